// File: doc/BRIEF.md
# Port change interrupt controller

This block is the interrupt path of an 8-bit quasi-bidirectional I/O expander. It keeps a port output latch and a reference snapshot of the pin levels. Whenever the synchronized pins differ from that snapshot, it drives an active-low open-drain interrupt. Because the interrupt comes from a comparison and not from a stored edge, a pin that returns to its earlier level clears the interrupt without any bus access.

The serial bus engine outside this block turns its sequences into single-cycle strobes. In a read, these are the address acknowledge and the read-from-port pulse. In a write, they are the data-byte acknowledge and the write-to-port pulse, which also carries a data byte. Every clear strobe copies the current synchronized pin levels into the snapshot and drops the interrupt. The write-to-port strobe also loads its byte into the port latch. The latch drives the weak pull-up enables of the quasi-bidirectional pins. The interrupt pin is modelled as an output enable paired with a data level that is always low, so several devices can share one wired line.

Top module: `pcx_irq_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `port_q` and `pullup_en` read 8'hFF, `irq_oe` is 0 and `irq_lvl` is 0. `irq_lvl` never leaves 0.
- R2: A rising or a falling change of any pin away from the reference sets `irq_oe`. A pin level applied before clock edge k gives `irq_oe`=1 after edge k+2 and `irq_oe`=0 after edge k+1.
- R3: When the pins return to the reference levels with no strobe, `irq_oe` goes to 0 with the same three-edge latency as R2.
- R4: A one-cycle `rd_addr_ack` pulse sampled at edge k gives `irq_oe`=0 after edge k. The pins are captured as the new reference, so the interrupt stays 0 while they stay still.
- R5: A `rd_port` pulse clears the interrupt and refreshes the reference in the same way as R4.
- R6: With the default `CLR_ON_DATA_ACK`=1, a `wr_data_ack` pulse clears the interrupt and refreshes the reference in the same way as R4.
- R7: A `wr_port` pulse sampled at edge k loads `wr_data` into `port_q` after edge k and clears the interrupt as in R4. `pullup_en` then equals `port_q`, where bit value 1 means the weak pull-up is on. Without `wr_port`, `port_q` holds its value.
- R8: After a clear, a later pin change sets `irq_oe` again with the R2 latency.
- R9: If a pin is held low while reset is active, `irq_oe` becomes 1 on the third edge after reset is released, because the reference starts at all ones.
- R10: A clear strobe takes priority over a mismatch in the same cycle. If a pin change reaches the synchronizer output on the same edge as the clear, `irq_oe` is 0 after that edge and 1 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pins_i | input | 8 | Raw pin levels, asynchronous |
| rd_addr_ack | input | 1 | Read sequence: slave address acknowledge strobe |
| rd_port | input | 1 | Read sequence: read-from-port strobe |
| wr_data_ack | input | 1 | Write sequence: data-byte acknowledge strobe |
| wr_port | input | 1 | Write sequence: write-to-port strobe |
| wr_data | input | 8 | Byte applied to the port latch on `wr_port` |
| port_q | output | 8 | Port output latch |
| pullup_en | output | 8 | Weak pull-up enable for each pin |
| irq_oe | output | 1 | Open-drain interrupt output enable, 1 while the interrupt is active |
| irq_lvl | output | 1 | Interrupt data level, always low |

## Verification
The pins are driven through single-bit rises, single-bit falls and returns to the reference level. Together these separate a true comparison from edge capture: a return must clear with no strobe, and only a comparison does that. Each of the four strobes is fired against a pending interrupt, and one write is also issued with no interrupt pending, so a latch load can be told apart from a clear. A pin held low through reset shows the all-ones start of the reference. A pin change timed to meet a clear on the same edge shows the clear winning first and the leftover mismatch returning one cycle later.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

  // Bus-side events that refresh the reference and drop the interrupt
  typedef struct packed {
    logic addr_ack_rd;
    logic port_rd;
    logic data_ack_wr;
    logic port_wr;
  } pcx_evt_t;

  // Number of fields in pcx_evt_t
  localparam int unsigned PCX_EVT_N = 4;

endpackage

// File: rtl/pcx_sync.sv
module pcx_sync #(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] raw_i,
  output logic [PORT_W-1:0] sync_o
);

  localparam logic [PORT_W-1:0] IDLE_LVL = {PORT_W{1'b1}};

  logic [PORT_W-1:0] stg [SYNC_STAGES];

  // Stage chain: the first stage takes the raw pins, the others shift
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= IDLE_LVL;
        else     stg[s] <= raw_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= IDLE_LVL;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign sync_o = stg[SYNC_STAGES-1];

endmodule

// File: rtl/pcx_clr_sel.sv
module pcx_clr_sel #(
  parameter bit CLR_ON_DATA_ACK = 1'b1
) (
  input  pcx_pkg::pcx_evt_t evt_i,
  output logic              clr_o
);

  // The parameter decides whether the write data acknowledge counts as a clear
  if (CLR_ON_DATA_ACK) begin : g_with_ack
    assign clr_o = evt_i.addr_ack_rd | evt_i.port_rd
                 | evt_i.data_ack_wr | evt_i.port_wr;
  end else begin : g_no_ack
    logic unused_ack;
    assign unused_ack = evt_i.data_ack_wr;
    assign clr_o = evt_i.addr_ack_rd | evt_i.port_rd | evt_i.port_wr;
  end

endmodule

// File: rtl/pcx_port_latch.sv
module pcx_port_latch #(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [PORT_W-1:0] data_i,
  output logic [PORT_W-1:0] latch_o,
  output logic [PORT_W-1:0] pullup_o
);

  localparam logic [PORT_W-1:0] POR_VAL = {PORT_W{1'b1}};

  logic [PORT_W-1:0] latch_q;
  logic [PORT_W-1:0] pullup_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q  <= POR_VAL;
      pullup_q <= POR_VAL;
    end else if (load_i) begin
      latch_q  <= data_i;
      pullup_q <= data_i;   // a 1 in the latch is a weakly pulled-up input
    end
  end

  assign latch_o  = latch_q;
  assign pullup_o = pullup_q;

endmodule

// File: rtl/pcx_ref_irq.sv
module pcx_ref_irq #(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic [PORT_W-1:0] pins_i,
  output logic              irq_o
);

  localparam logic [PORT_W-1:0] POR_VAL = {PORT_W{1'b1}};

  logic [PORT_W-1:0] ref_q;
  logic [PORT_W-1:0] diff;
  logic              irq_q;

  assign diff = pins_i ^ ref_q;

  // The reference takes the current pins on every clear event
  always_ff @(posedge clk) begin
    if (rst)        ref_q <= POR_VAL;
    else if (clr_i) ref_q <= pins_i;
  end

  // A clear wins over a mismatch seen in the same cycle
  always_ff @(posedge clk) begin
    if (rst)        irq_q <= 1'b0;
    else if (clr_i) irq_q <= 1'b0;
    else            irq_q <= |diff;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/pcx_irq_top.sv
module pcx_irq_top #(
  parameter int unsigned PORT_W          = 8,
  parameter int unsigned SYNC_STAGES     = 2,
  parameter bit          CLR_ON_DATA_ACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] pins_i,
  input  logic              rd_addr_ack,
  input  logic              rd_port,
  input  logic              wr_data_ack,
  input  logic              wr_port,
  input  logic [PORT_W-1:0] wr_data,
  output logic [PORT_W-1:0] port_q,
  output logic [PORT_W-1:0] pullup_en,
  output logic              irq_oe,
  output logic              irq_lvl
);

  pcx_pkg::pcx_evt_t evt;
  logic              clr;
  logic [PORT_W-1:0] pins_s;

  assign evt.addr_ack_rd = rd_addr_ack;
  assign evt.port_rd     = rd_port;
  assign evt.data_ack_wr = wr_data_ack;
  assign evt.port_wr     = wr_port;

  pcx_sync #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (pins_i),
    .sync_o (pins_s)
  );

  pcx_clr_sel #(.CLR_ON_DATA_ACK(CLR_ON_DATA_ACK)) u_clr (
    .evt_i (evt),
    .clr_o (clr)
  );

  pcx_port_latch #(.PORT_W(PORT_W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .load_i   (wr_port),
    .data_i   (wr_data),
    .latch_o  (port_q),
    .pullup_o (pullup_en)
  );

  pcx_ref_irq #(.PORT_W(PORT_W)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr),
    .pins_i (pins_s),
    .irq_o  (irq_oe)
  );

  // Open-drain: the pin only ever pulls low or floats
  assign irq_lvl = 1'b0;

endmodule

// File: rtl/pcx_irq_chk.sv
module pcx_irq_chk #(
  parameter int unsigned PORT_W          = 8,
  parameter bit          CLR_ON_DATA_ACK = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_addr_ack,
  input logic              rd_port,
  input logic              wr_data_ack,
  input logic              wr_port,
  input logic [PORT_W-1:0] wr_data,
  input logic [PORT_W-1:0] port_q,
  input logic [PORT_W-1:0] pullup_en,
  input logic              irq_oe
);

  logic any_clr;
  assign any_clr = rd_addr_ack | rd_port | wr_port
                 | (CLR_ON_DATA_ACK ? wr_data_ack : 1'b0);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (port_q == {PORT_W{1'b1}} && pullup_en == {PORT_W{1'b1}} && !irq_oe)); // R1

  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (rst)
    any_clr |=> !irq_oe); // R4

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    wr_port |=> (port_q == $past(wr_data) && pullup_en == $past(wr_data))); // R7

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_port |=> $stable(port_q)); // R7

  AST_NO_RISE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_oe) |-> !$past(any_clr)); // R10

endmodule

bind pcx_irq_top pcx_irq_chk #(
  .PORT_W(PORT_W),
  .CLR_ON_DATA_ACK(CLR_ON_DATA_ACK)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rd_addr_ack (rd_addr_ack),
  .rd_port     (rd_port),
  .wr_data_ack (wr_data_ack),
  .wr_port     (wr_port),
  .wr_data     (wr_data),
  .port_q      (port_q),
  .pullup_en   (pullup_en),
  .irq_oe      (irq_oe)
);

// File: tb/sim_pcx_irq_top.sv
module sim_pcx_irq_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pins_i = 8'hFE;
  logic       rd_addr_ack = 1'b0;
  logic       rd_port = 1'b0;
  logic       wr_data_ack = 1'b0;
  logic       wr_port = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] port_q;
  logic [7:0] pullup_en;
  logic       irq_oe;
  logic       irq_lvl;

  always #2.5 clk = ~clk;   // 200 MHz

  pcx_irq_top u0 (
    .clk(clk), .rst(rst), .pins_i(pins_i),
    .rd_addr_ack(rd_addr_ack), .rd_port(rd_port),
    .wr_data_ack(wr_data_ack), .wr_port(wr_port), .wr_data(wr_data),
    .port_q(port_q), .pullup_en(pullup_en), .irq_oe(irq_oe), .irq_lvl(irq_lvl)
  );

  typedef struct {
    int         cyc;
    logic       irq;
    logic [7:0] port;
    string      tag;
  } item_t;

  item_t      sb[$];
  int         cyc = 0;
  int         checks = 0;
  int         errors = 0;
  logic [7:0] exp_port = 8'hFF;
  bit         done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Driver side: schedule an expected output state d cycles from now
  task automatic expect_at(input int d, input logic irq, input string tag);
    item_t it;
    it.cyc = cyc + d; it.irq = irq; it.port = exp_port; it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (it.cyc != cyc || irq_oe !== it.irq || port_q !== it.port ||
          pullup_en !== it.port || irq_lvl !== 1'b0) begin
        errors++;
        $display("FAIL %s cyc=%0d: irq_oe=%b port_q=%h pullup_en=%h irq_lvl=%b expected irq_oe=%b port=%h lvl=0 at cyc %0d",
                 it.tag, cyc, irq_oe, port_q, pullup_en, irq_lvl, it.irq, it.port, it.cyc);
      end
    end
  end

  task automatic set_pins(input logic [7:0] v, input logic was, input logic now, input string tag);
    pins_i = v;
    expect_at(2, was, tag);
    expect_at(3, now, tag);
    repeat (4) @(negedge clk);
  endtask

  // which: 0 addr ack, 1 read port, 2 data ack, 3 write port
  task automatic strobe(input int which, input logic [7:0] d, input string tag);
    case (which)
      0: rd_addr_ack = 1'b1;
      1: rd_port     = 1'b1;
      2: wr_data_ack = 1'b1;
      default: begin wr_port = 1'b1; wr_data = d; exp_port = d; end
    endcase
    expect_at(1, 1'b0, tag);
    expect_at(3, 1'b0, tag);
    @(negedge clk);
    rd_addr_ack = 1'b0; rd_port = 1'b0; wr_data_ack = 1'b0; wr_port = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state, R9 pin held low through reset asserts on third edge
    expect_at(1, 1'b0, "R1 reset state");
    expect_at(2, 1'b0, "R9 before latency");
    expect_at(3, 1'b1, "R9 low pin after reset");
    repeat (4) @(negedge clk);

    strobe(0, 8'h00, "R4 address ack clear");
    set_pins(8'hFF, 1'b0, 1'b1, "R2 rising bit0");
    set_pins(8'hFE, 1'b1, 1'b0, "R3 return to reference");
    set_pins(8'h7E, 1'b0, 1'b1, "R2 falling bit7");
    strobe(1, 8'h00, "R5 read port clear");
    set_pins(8'h76, 1'b0, 1'b1, "R8 change after clear");
    strobe(2, 8'h00, "R6 data ack clear");
    strobe(3, 8'hA5, "R7 write with no pending irq");
    set_pins(8'h77, 1'b0, 1'b1, "R8 second change");
    strobe(3, 8'h5A, "R7 write clears and loads");

    // R10: change reaches the synchronizer output on the clear edge
    pins_i = 8'hF7;
    expect_at(1, 1'b0, "R10 before clear");
    @(negedge clk);
    rd_port = 1'b1;
    expect_at(1, 1'b0, "R10 clear wins");
    expect_at(2, 1'b1, "R10 mismatch reasserts");
    @(negedge clk);
    rd_port = 1'b0;
    repeat (4) @(negedge clk);

    strobe(1, 8'h00, "R5 clear after R10");
    wait (sb.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule